// File: doc/BRIEF.md
# Per-Pin Port Interrupt Controller

This block watches the 32 input pins of one general-purpose port and turns selected pin activity into pending flags. Every pin has its own 4-bit mode register that chooses what it reacts to. A pin can react to a low or high level, or to a rising, falling or either edge. The mode also chooses where the event goes. Interrupt-mode flags drive one combined interrupt line for the port. DMA-mode flags drive a request line toward a DMA engine.

Each pin input passes through a two-flop synchroniser before detection. An edge is found by comparing the synchronised value with its value one cycle earlier. The pending flags sit together in one status word, and software clears them by writing ones to it. DMA-mode flags are cleared instead by an acknowledge pulse from the DMA side. Level-mode flags keep setting again for as long as the level stays present.

A simple register bus gives access to the mode registers and the status word. A write takes effect on the clock edge where it is presented. Read data is combinational from the address.

Top module: `pin_event_ctrl`

## Requirements
- R1: After reset, every flag and every mode register is zero, and irq_o and dma_req_o are low.
- R2: Word address p (0 to 31) holds the mode of pin p in data bits [3:0], and the upper write bits are dropped. Address 32 holds the status word, with bit p being pin p's flag. Every other address reads zero.
- R3: Code 9 detects a rising edge, code 10 a falling edge and code 11 either edge, all in interrupt mode. The flag is readable three clock edges after the pin changes (two synchroniser flops plus the flag register).
- R4: Code 8 sets the flag in every cycle the synchronised pin is 0. Code 12 sets it in every cycle the synchronised pin is 1. Once the level is gone and the flag is cleared, it stays clear.
- R5: A write to the status word clears each flag whose data bit is 1 and leaves flags under 0 bits unchanged. Writing all ones clears every flag.
- R6: In a level mode, a flag cleared while its level is still present reads 0 for one cycle and is set again on the next clock edge.
- R7: Code 0, and any code not listed in R3, R4 or R9, sets no new flag. A flag that is already clear stays clear whatever the pin does.
- R8: irq_o is high exactly when some pin in an interrupt mode (codes 8 to 12) has its flag set. DMA-mode flags never raise it.
- R9: Codes 1, 2 and 3 detect rising, falling and either edge for DMA. dma_req_o is high while any DMA-mode flag is set. A dma_ack_i pulse clears all DMA-mode flags and leaves interrupt-mode flags alone.
- R10: When an edge event and a status clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 32 | Asynchronous port pin levels |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Combined port interrupt |
| dma_req_o | output | 1 | DMA request |
| dma_ack_i | input | 1 | DMA completion pulse |

## Verification
Some rules are checked by assertions on every cycle. An edge event must match a real change of the synchronised level. A flag with an edge event stays set even under a clear. A cleared flag with no edge event drops. A flag on a disabled pin stays low. When no flag is pending, both outputs stay quiet. Other behaviour can only be shown by the bench scenarios: the exact three-edge latency, the one-cycle gap before a level flag sets again, the split between interrupt and DMA routing, and the acknowledge leaving interrupt flags alone.

// File: rtl/pev_pkg.sv
`timescale 1ns/1ps
package pev_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_OFF      = 4'd0,
    MD_DMA_RISE = 4'd1,
    MD_DMA_FALL = 4'd2,
    MD_DMA_BOTH = 4'd3,
    MD_IRQ_LOW  = 4'd8,
    MD_IRQ_RISE = 4'd9,
    MD_IRQ_FALL = 4'd10,
    MD_IRQ_BOTH = 4'd11,
    MD_IRQ_HIGH = 4'd12
  } mode_e;

  typedef struct packed {
    logic on_rise;
    logic on_fall;
    logic on_low;
    logic on_high;
    logic to_dma;
    logic to_irq;
  } sense_t;

  function automatic sense_t decode_mode(logic [MODE_W-1:0] code);
    sense_t s;
    s = '0;
    case (code)
      MD_DMA_RISE: begin s.on_rise = 1'b1; s.to_dma = 1'b1; end
      MD_DMA_FALL: begin s.on_fall = 1'b1; s.to_dma = 1'b1; end
      MD_DMA_BOTH: begin s.on_rise = 1'b1; s.on_fall = 1'b1; s.to_dma = 1'b1; end
      MD_IRQ_LOW:  begin s.on_low  = 1'b1; s.to_irq = 1'b1; end
      MD_IRQ_RISE: begin s.on_rise = 1'b1; s.to_irq = 1'b1; end
      MD_IRQ_FALL: begin s.on_fall = 1'b1; s.to_irq = 1'b1; end
      MD_IRQ_BOTH: begin s.on_rise = 1'b1; s.on_fall = 1'b1; s.to_irq = 1'b1; end
      MD_IRQ_HIGH: begin s.on_high = 1'b1; s.to_irq = 1'b1; end
      default:     s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pev_sync.sv
`timescale 1ns/1ps
module pev_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] stab_q, stab_d;

  always_comb begin
    meta_d = async_i;
    stab_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign sync_o = stab_q;

endmodule

// File: rtl/pev_detect.sv
`timescale 1ns/1ps
module pev_detect
  import pev_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PINS-1:0]          lvl_i,
  input  logic [NUM_PINS*MODE_W-1:0]   mode_i,
  output logic [NUM_PINS-1:0]          edge_evt_o,
  output logic [NUM_PINS-1:0]          level_evt_o,
  output logic [NUM_PINS-1:0]          dma_sel_o,
  output logic [NUM_PINS-1:0]          irq_sel_o
);

  logic [NUM_PINS-1:0] prev_q, prev_d;

  always_comb prev_d = lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    sense_t sense;
    logic   rose, fell;

    assign sense = decode_mode(mode_i[g*MODE_W +: MODE_W]);
    assign rose  = lvl_i[g] & ~prev_q[g];
    assign fell  = ~lvl_i[g] & prev_q[g];

    assign edge_evt_o[g]  = (sense.on_rise & rose) | (sense.on_fall & fell);
    assign level_evt_o[g] = (sense.on_low & ~lvl_i[g]) | (sense.on_high & lvl_i[g]);
    assign dma_sel_o[g]   = sense.to_dma;
    assign irq_sel_o[g]   = sense.to_irq;

    // R3: an edge event needs a real change of the synchronised level
    p_edge_is_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt_o[g] |-> (lvl_i[g] != $past(lvl_i[g])));
  end

endmodule

// File: rtl/pev_flags.sv
`timescale 1ns/1ps
module pev_flags #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_edge_i,
  input  logic [NUM_PINS-1:0] set_level_i,
  input  logic [NUM_PINS-1:0] clr_sw_i,
  input  logic [NUM_PINS-1:0] clr_dma_i,
  output logic [NUM_PINS-1:0] flags_o
);

  logic [NUM_PINS-1:0] flags_q, flags_d;
  logic [NUM_PINS-1:0] clr_any, set_any;

  always_comb begin
    clr_any = clr_sw_i | clr_dma_i;
    // level sets yield to a clear in the same cycle and return one cycle later
    set_any = set_edge_i | (set_level_i & ~clr_any);
    flags_d = (flags_q & ~clr_any) | set_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R10: an edge event always leaves its flag set, even under a clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_edge_i != '0) |=> ((flags_q & $past(set_edge_i)) == $past(set_edge_i)));

  // R5: a cleared flag without an edge event reads zero afterwards
  p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sw_i != '0) |=> ((flags_q & $past(clr_sw_i & ~set_edge_i)) == '0));

  // R9: an acknowledged flag without an edge event reads zero afterwards
  p_ack_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_dma_i != '0) |=> ((flags_q & $past(clr_dma_i & ~set_edge_i)) == '0));

endmodule

// File: rtl/pin_event_ctrl.sv
`timescale 1ns/1ps
module pin_event_ctrl
  import pev_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_PINS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_sel_i,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                irq_o,
  output logic                dma_req_o,
  input  logic                dma_ack_i
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_PINS);
  localparam int                MODES_W   = NUM_PINS * MODE_W;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // mode registers
  logic               bus_wr_stb;
  logic               mode_we;
  logic [MODES_W-1:0] mode_q, mode_d;

  assign bus_wr_stb = bus_sel_i & bus_wr_i;
  assign mode_we    = bus_wr_stb & (bus_addr_i < STAT_ADDR);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_mode
    logic hit;
    assign hit = bus_wr_stb & (bus_addr_i == ADDR_W'(g));
    assign mode_d[g*MODE_W +: MODE_W] =
      hit ? bus_wdata_i[MODE_W-1:0] : mode_q[g*MODE_W +: MODE_W];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   mode_q <= '0;
    else if (mode_we) mode_q <= mode_d;
  end

  // synchroniser, detection, flags
  logic [NUM_PINS-1:0] lvl_sync;
  logic [NUM_PINS-1:0] edge_evt, level_evt, dma_sel, irq_sel;
  logic [NUM_PINS-1:0] clr_sw, clr_dma, flags;

  pev_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (pin_i),
    .sync_o  (lvl_sync)
  );

  pev_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .lvl_i       (lvl_sync),
    .mode_i      (mode_q),
    .edge_evt_o  (edge_evt),
    .level_evt_o (level_evt),
    .dma_sel_o   (dma_sel),
    .irq_sel_o   (irq_sel)
  );

  assign clr_sw  = (bus_wr_stb && bus_addr_i == STAT_ADDR) ?
                   bus_wdata_i[NUM_PINS-1:0] : '0;
  assign clr_dma = dma_ack_i ? dma_sel : '0;

  pev_flags #(.NUM_PINS(NUM_PINS)) u_flags (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .set_edge_i  (edge_evt),
    .set_level_i (level_evt),
    .clr_sw_i    (clr_sw),
    .clr_dma_i   (clr_dma),
    .flags_o     (flags)
  );

  // outputs
  assign irq_o     = |(flags & irq_sel);
  assign dma_req_o = |(flags & dma_sel);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i < STAT_ADDR)
      bus_rdata_o = DATA_W'(mode_q[int'(bus_addr_i)*MODE_W +: MODE_W]);
    else if (bus_addr_i == STAT_ADDR)
      bus_rdata_o = DATA_W'(flags);
  end

  logic [NUM_PINS-1:0] off_mask;
  assign off_mask = ~(dma_sel | irq_sel);

  // R7: a clear flag on a disabled pin stays clear
  p_off_stays_clear_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> ((flags & $past(off_mask & ~flags)) == '0));

  // R8, R9: no pending flag means both request lines are low
  p_quiet_outputs_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flags == '0) |-> (!irq_o && !dma_req_o));

endmodule

// File: tb/test_pin_event_ctrl.sv
`timescale 1ns/1ps
module test_pin_event_ctrl;

  logic        clk;
  logic        rst_n;
  logic [31:0] pins;
  logic        bus_sel, bus_wr, dma_ack;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, dma_req;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  pin_event_ctrl i_pin_event_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pins),
    .bus_sel_i   (bus_sel),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq),
    .dma_req_o   (dma_req),
    .dma_ack_i   (dma_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // scoreboard queues: kind 0 = read data, 1 = irq_o, 2 = dma_req_o
  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        probe;

  initial begin
    forever begin
      @(probe);
      #0.1;
      begin
        int          k;
        logic [31:0] e, a;
        string       t;
        k = kind_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = (k == 0) ? bus_rdata : (k == 1) ? {31'b0, irq} : {31'b0, dma_req};
        n_checks++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: kind %0d got %h expected %h", t, k, a, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected below 20000", cycles);
      finish_run();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic push(int k, logic [31:0] e, string t);
    kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
    ->probe;
    #0.2;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string t);
    bus_addr = a;
    push(0, e, t);
  endtask

  task automatic chk_irq(logic e, string t);
    push(1, {31'b0, e}, t);
  endtask

  task automatic chk_dma(logic e, string t);
    push(2, {31'b0, e}, t);
  endtask

  task automatic ack_pulse();
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; pins = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; dma_ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1: reset state
    rd(6'd32, 32'h0, "R1 status");
    rd(6'd5, 32'h0, "R1 mode");
    chk_irq(1'b0, "R1 irq");
    chk_dma(1'b0, "R1 dma");

    // R2: mode readback, upper bits dropped, unmapped address
    wr(6'd4, 32'hABCD_0012);
    rd(6'd4, 32'h2, "R2 mode field");
    wr(6'd4, 32'h0);
    wr(6'd3, 32'd9);
    rd(6'd3, 32'd9, "R2 mode readback");
    rd(6'd40, 32'h0, "R2 unmapped");

    // R3: rising edge, three-edge latency
    pins[3] = 1'b1;
    tick(2);
    rd(6'd32, 32'h0, "R3 not yet");
    tick(1);
    rd(6'd32, 32'h8, "R3 rising");
    chk_irq(1'b1, "R8 irq on");

    // R5: write-one-to-clear
    wr(6'd32, 32'hFFFF_FFF7);
    rd(6'd32, 32'h8, "R5 zero bit keeps");
    wr(6'd32, 32'h8);
    rd(6'd32, 32'h0, "R5 one bit clears");
    chk_irq(1'b0, "R8 irq off");

    // R7 then R3: falling edge
    pins[5] = 1'b1;
    tick(3);
    rd(6'd32, 32'h0, "R7 mode zero");
    wr(6'd5, 32'd10);
    pins[5] = 1'b0;
    tick(3);
    rd(6'd32, 32'h20, "R3 falling");
    wr(6'd32, 32'h20);

    // R3: either edge
    wr(6'd7, 32'd11);
    pins[7] = 1'b1;
    tick(3);
    rd(6'd32, 32'h80, "R3 either rise");
    wr(6'd32, 32'h80);
    pins[7] = 1'b0;
    tick(3);
    rd(6'd32, 32'h80, "R3 either fall");
    wr(6'd32, 32'h80);
    rd(6'd32, 32'h0, "R5 cleared");

    // R4 / R6: level low
    wr(6'd9, 32'd8);
    tick(1);
    rd(6'd32, 32'h200, "R4 level low");
    chk_irq(1'b1, "R8 level irq");
    wr(6'd32, 32'h200);
    rd(6'd32, 32'h0, "R6 gap cycle");
    tick(1);
    rd(6'd32, 32'h200, "R6 set again");
    pins[9] = 1'b1;
    tick(3);
    wr(6'd32, 32'h200);
    tick(2);
    rd(6'd32, 32'h0, "R4 level gone");
    wr(6'd9, 32'd0);

    // R4 / R6: level high
    wr(6'd10, 32'd12);
    tick(2);
    rd(6'd32, 32'h0, "R4 high idle");
    pins[10] = 1'b1;
    tick(3);
    rd(6'd32, 32'h400, "R4 level high");
    wr(6'd32, 32'h400);
    rd(6'd32, 32'h0, "R6 high gap");
    tick(1);
    rd(6'd32, 32'h400, "R6 high again");
    wr(6'd10, 32'd0);
    wr(6'd32, 32'h400);
    tick(2);
    rd(6'd32, 32'h0, "R7 high disabled");

    // R7: disabled and unlisted codes
    wr(6'd3, 32'd0);
    pins[3] = 1'b0;
    tick(3);
    pins[3] = 1'b1;
    tick(3);
    rd(6'd32, 32'h0, "R7 code zero");
    wr(6'd11, 32'd5);
    pins[11] = 1'b1;
    tick(3);
    pins[11] = 1'b0;
    tick(3);
    rd(6'd32, 32'h0, "R7 unlisted code");

    // R9: DMA rising with an interrupt flag alongside
    wr(6'd12, 32'd1);
    pins[12] = 1'b1;
    tick(3);
    rd(6'd32, 32'h1000, "R9 dma flag");
    chk_dma(1'b1, "R9 dma req");
    chk_irq(1'b0, "R8 dma not irq");
    pins[7] = 1'b1;
    tick(3);
    rd(6'd32, 32'h1080, "R9 both flags");
    chk_irq(1'b1, "R8 irq with dma");
    ack_pulse();
    rd(6'd32, 32'h80, "R9 ack clears dma only");
    chk_dma(1'b0, "R9 dma req off");
    chk_irq(1'b1, "R8 irq kept");
    wr(6'd32, 32'h80);

    // R9: DMA falling
    wr(6'd4, 32'd2);
    pins[4] = 1'b1;
    tick(3);
    rd(6'd32, 32'h0, "R9 falling ignores rise");
    pins[4] = 1'b0;
    tick(3);
    chk_dma(1'b1, "R9 falling req");
    ack_pulse();
    chk_dma(1'b0, "R9 falling ack");

    // R10: edge event and clear in the same cycle
    wr(6'd14, 32'd11);
    pins[14] = 1'b1;
    tick(3);
    rd(6'd32, 32'h4000, "R10 setup");
    pins[14] = 1'b0;
    tick(2);
    wr(6'd32, 32'h4000);
    rd(6'd32, 32'h4000, "R10 set wins");
    wr(6'd32, 32'h4000);
    rd(6'd32, 32'h0, "R5 later clear");

    // R5: clear all at once
    pins[7]  = 1'b0;
    pins[14] = 1'b1;
    tick(3);
    rd(6'd32, 32'h4080, "R5 two pending");
    wr(6'd32, 32'hFFFF_FFFF);
    rd(6'd32, 32'h0, "R5 clear all");
    chk_irq(1'b0, "R8 all clear");

    tick(2);
    finish_run();
  end

endmodule